// File: doc/BRIEF.md
# Character-Cell Video Fetch and Raster Scaler

This block sits between a raster timing generator and a pair of video memories. Every pixel clock it takes the current horizontal and vertical raster position of a 1024×768, 60 Hz display (65 MHz pixel clock). It maps that position back onto a 256×192 picture made of 32×24 character cells of 8×8 pixels. For that cell it drives a read address into the bitmap memory and a read address into the attribute memory. From the returned bytes it forms a 4-bit colour. Inside the visible raster but outside the scaled picture, it shows the border colour that the CPU port holds. Outside the visible raster, it outputs black.

Both memories are expected to capture their address on the falling edge of the pixel clock. The data therefore arrive within the same pixel period and are combined at the next rising edge. A two-bit scale selector picks the picture magnification: ×4 fills the screen, while ×2 and ×1 leave a wider border, with the picture always centred. The bitmap address interleaves the row bits so that the 192 rows form three bands of 64 rows. The attribute address is linear in cell row and cell column. The addresses are byte offsets into each memory; in the CPU's view the bitmap begins at 0x4000 and the attributes at 0x5800.

Top module: `cellvid_raster`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pix_color` becomes 0 after that edge, whatever the other inputs are.
- R2: For picture coordinates x (0..255) and y (0..191), `bmp_addr` is the 13-bit value {y[7:6], y[2:0], y[5:3], x[7:3]}.
- R3: For the same coordinates, `attr_addr` is y[7:3]×32 + x[7:3] as a 10-bit value.
- R4: The pixel bit is bit (7 − x[2:0]) of the bitmap byte, so the MSB is the leftmost pixel. A 1 selects ink and a 0 selects paper.
- R5: The attribute byte is decoded as bit 7 flash, bit 6 bright, bits 5:3 paper and bits 2:0 ink. Inside the picture, `pix_color` is {bright, chosen colour}, where each colour is {G, R, B} with G in bit 2.
- R6: When the attribute flash bit is 1 and `flash_clk` is 1, ink and paper swap roles. With either of them at 0, no swap takes place.
- R7: `scale_sel` = 0 selects ×4 with origin (0,0). A value of 1 selects ×2 with origin (256,192). Values 2 and 3 select ×1 with origin (384,288). Picture coordinates are the raster offset from the origin divided by the scale.
- R8: Within h < 1024 and v < 768 but outside the scaled picture, `pix_color` is {0, `border_col`}.
- R9: When h ≥ 1024 or v ≥ 768, `pix_color` is 0.
- R10: `pix_color` changes only at a rising edge. After the edge, it reflects the inputs and memory data present before that edge, which is one cycle of latency from the raster position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock (rising edge) |
| rst_n | input | 1 | Synchronous active-low reset |
| h_pos | input | 11 | Raster column from the timing generator |
| v_pos | input | 11 | Raster line from the timing generator |
| scale_sel | input | 2 | Magnification select (0: ×4, 1: ×2, 2/3: ×1) |
| border_col | input | 3 | Border colour {G,R,B} from the CPU port |
| flash_clk | input | 1 | Flash phase; high means swap flashing cells |
| bmp_addr | output | 13 | Bitmap memory byte offset |
| bmp_q | input | 8 | Bitmap memory read data (captured on falling edge) |
| attr_addr | output | 10 | Attribute memory byte offset |
| attr_q | input | 8 | Attribute memory read data (captured on falling edge) |
| pix_color | output | 4 | Registered pixel colour {bright, G, R, B} |

## Verification
The main function is driven with raster positions that land on the first and last picture pixels in every scale mode. Matching those against a reference model shows whether origins and divisors are right, because a wrong origin moves the picture edge into the border. The positions just outside the picture and beyond the visible raster separate border from blanking. Hand-chosen coordinates with distinct bits in every y field separate the three-band address interleave from a linear layout. A single-bit bitmap byte read at two adjacent columns tells MSB-first from LSB-first order. A flashing attribute with distinct ink and paper, read with both flash phases, shows the swap and its absence.

// File: rtl/cellvid_pkg.sv
// Shared types and helpers for the character-cell video fetch block.
// Assumes a 256x192 picture of 8x8 cells and 8-bit bitmap/attribute bytes.
package cellvid_pkg;

    localparam int COORD_W    = 8;   // picture coordinate width (0..255)
    localparam int NUM_SCALES = 3;   // shift 0 (x1), 1 (x2), 2 (x4)

    typedef struct packed {
        logic       flash;
        logic       bright;
        logic [2:0] paper;
        logic [2:0] ink;
    } cell_attr_t;

    // Pick ink or paper for one pixel, honouring the flash swap.
    function automatic logic [3:0] cell_colour(input cell_attr_t a,
                                               input logic bit_on,
                                               input logic flash_phase);
        logic use_ink;
        use_ink = bit_on ^ (a.flash & flash_phase);
        return {a.bright, (use_ink ? a.ink : a.paper)};
    endfunction

endpackage

// File: rtl/cellvid_window.sv
// Maps a raster position to picture coordinates for the selected scale.
// Builds one centred window per magnification and picks one by scale_sel.
// Assumes the raster is at least as large as the x4 picture.
module cellvid_window
    import cellvid_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int H_VIS = 1024,
    parameter int V_VIS = 768,
    parameter int ACT_W = 256,
    parameter int ACT_H = 192
) (
    input  logic [CNT_W-1:0]   h_pos,
    input  logic [CNT_W-1:0]   v_pos,
    input  logic [1:0]         scale_sel,
    output logic               visible,
    output logic               active,
    output logic [COORD_W-1:0] col,
    output logic [COORD_W-1:0] row
);

    localparam int EXT_W = CNT_W + 1;

    logic               hit   [NUM_SCALES];
    logic [COORD_W-1:0] col_g [NUM_SCALES];
    logic [COORD_W-1:0] row_g [NUM_SCALES];

    // One centred window per magnification; an offset below the origin wraps large.
    for (genvar g = 0; g < NUM_SCALES; g++) begin : g_scale
        localparam int SPAN_X = ACT_W << g;
        localparam int SPAN_Y = ACT_H << g;
        localparam int ORG_X  = (H_VIS - SPAN_X) / 2;
        localparam int ORG_Y  = (V_VIS - SPAN_Y) / 2;

        logic [EXT_W-1:0] dx;
        logic [EXT_W-1:0] dy;

        assign dx       = {1'b0, h_pos} - EXT_W'(ORG_X);
        assign dy       = {1'b0, v_pos} - EXT_W'(ORG_Y);
        assign hit[g]   = (dx < EXT_W'(SPAN_X)) && (dy < EXT_W'(SPAN_Y));
        assign col_g[g] = COORD_W'(dx >> g);
        assign row_g[g] = COORD_W'(dy >> g);
    end

    // Flags the part of the raster that is shown at all.
    always_comb begin
        visible = (h_pos < CNT_W'(H_VIS)) && (v_pos < CNT_W'(V_VIS));
    end

    // Selects the window for the requested magnification.
    always_comb begin
        unique case (scale_sel)
            2'd0: begin
                active = hit[2];
                col    = col_g[2];
                row    = row_g[2];
            end
            2'd1: begin
                active = hit[1];
                col    = col_g[1];
                row    = row_g[1];
            end
            default: begin
                active = hit[0];
                col    = col_g[0];
                row    = row_g[0];
            end
        endcase
    end

endmodule

// File: rtl/cellvid_fetch_addr.sv
// Forms the bitmap and attribute memory offsets for a picture coordinate.
// The bitmap rows are interleaved in three bands of 64 lines; attributes are linear.
// Assumes 32 cells per row; outputs are meaningful only inside the picture.
module cellvid_fetch_addr
    import cellvid_pkg::*;
#(
    parameter int BMP_AW  = 13,
    parameter int ATTR_AW = 10
) (
    input  logic [COORD_W-1:0] col,
    input  logic [COORD_W-1:0] row,
    output logic [BMP_AW-1:0]  bmp_addr,
    output logic [ATTR_AW-1:0] attr_addr
);

    logic [4:0] cell_col;
    logic [4:0] cell_row;

    // Splits the coordinates into cell indices.
    always_comb begin
        cell_col = col[7:3];
        cell_row = row[7:3];
    end

    // Bitmap offset: band, line within cell, cell row within band, cell column.
    always_comb begin
        bmp_addr = BMP_AW'({row[7:6], row[2:0], row[5:3], cell_col});
    end

    // Attribute offset: one byte per cell, 32 cells per row.
    always_comb begin
        attr_addr = ATTR_AW'({cell_row, cell_col});
    end

endmodule

// File: rtl/cellvid_shade.sv
// Chooses the pixel colour from bitmap and attribute bytes, border or blank,
// and registers it. Assumes the memory data belong to the current position.
module cellvid_shade
    import cellvid_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       visible,
    input  logic       active,
    input  logic [2:0] pix_idx,
    input  logic [7:0] bmp_q,
    input  logic [7:0] attr_q,
    input  logic       flash_clk,
    input  logic [2:0] border_col,
    output logic [3:0] pix_color
);

    logic       bit_on;
    logic [3:0] next_colour;

    // Picks the bitmap bit for this pixel, MSB first.
    always_comb begin
        bit_on = bmp_q[3'd7 - pix_idx];
    end

    // Chooses picture, border or blank colour.
    always_comb begin
        if (!visible) begin
            next_colour = 4'd0;
        end else if (!active) begin
            next_colour = {1'b0, border_col};
        end else begin
            next_colour = cell_colour(cell_attr_t'(attr_q), bit_on, flash_clk);
        end
    end

    // Output register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_color <= 4'd0;
        end else begin
            pix_color <= next_colour;
        end
    end

endmodule

// File: rtl/cellvid_raster.sv
// Top of the character-cell video fetch block: window mapping, memory
// addressing and colour selection. Assumes memories that capture the
// address on the falling clock edge and return data before the next rise.
module cellvid_raster
    import cellvid_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int H_VIS   = 1024,
    parameter int V_VIS   = 768,
    parameter int ACT_W   = 256,
    parameter int ACT_H   = 192,
    parameter int BMP_AW  = 13,
    parameter int ATTR_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   h_pos,
    input  logic [CNT_W-1:0]   v_pos,
    input  logic [1:0]         scale_sel,
    input  logic [2:0]         border_col,
    input  logic               flash_clk,
    output logic [BMP_AW-1:0]  bmp_addr,
    input  logic [7:0]         bmp_q,
    output logic [ATTR_AW-1:0] attr_addr,
    input  logic [7:0]         attr_q,
    output logic [3:0]         pix_color
);

    logic               visible;
    logic               active;
    logic [COORD_W-1:0] col;
    logic [COORD_W-1:0] row;

    cellvid_window #(
        .CNT_W (CNT_W),
        .H_VIS (H_VIS),
        .V_VIS (V_VIS),
        .ACT_W (ACT_W),
        .ACT_H (ACT_H)
    ) u_window (
        .h_pos     (h_pos),
        .v_pos     (v_pos),
        .scale_sel (scale_sel),
        .visible   (visible),
        .active    (active),
        .col       (col),
        .row       (row)
    );

    cellvid_fetch_addr #(
        .BMP_AW  (BMP_AW),
        .ATTR_AW (ATTR_AW)
    ) u_addr (
        .col       (col),
        .row       (row),
        .bmp_addr  (bmp_addr),
        .attr_addr (attr_addr)
    );

    cellvid_shade u_shade (
        .clk        (clk),
        .rst_n      (rst_n),
        .visible    (visible),
        .active     (active),
        .pix_idx    (col[2:0]),
        .bmp_q      (bmp_q),
        .attr_q     (attr_q),
        .flash_clk  (flash_clk),
        .border_col (border_col),
        .pix_color  (pix_color)
    );

endmodule

// File: rtl/cellvid_raster_chk.sv
// Property checker for cellvid_raster, attached by bind.
module cellvid_raster_chk #(
    parameter int CNT_W = 11,
    parameter int H_VIS = 1024,
    parameter int V_VIS = 768,
    parameter int ACT_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] h_pos,
    input logic [CNT_W-1:0] v_pos,
    input logic [1:0]       scale_sel,
    input logic [2:0]       border_col,
    input logic [7:0]       attr_q,
    input logic [3:0]       pix_color
);

    localparam int ORG_X1 = (H_VIS - ACT_W) / 2;

    // R9: columns past the visible raster give black one edge later.
    assert_hblank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pos >= CNT_W'(H_VIS)) |=> (pix_color == 4'd0));

    // R9: lines past the visible raster give black one edge later.
    assert_vblank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (v_pos >= CNT_W'(V_VIS)) |=> (pix_color == 4'd0));

    // R8: left border in the x1 mode shows the border colour.
    assert_border_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((scale_sel == 2'd2) && (h_pos < CNT_W'(ORG_X1)) && (v_pos < CNT_W'(V_VIS)))
        |=> (pix_color == {1'b0, $past(border_col)}));

    // R5: in x4 mode the whole visible raster is picture, so bright comes from the attribute.
    assert_bright_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((scale_sel == 2'd0) && (h_pos < CNT_W'(H_VIS)) && (v_pos < CNT_W'(V_VIS)))
        |=> (pix_color[3] == $past(attr_q[6])));

    // R5: with equal ink and paper the colour field is that value whatever the bit.
    assert_flat_cell_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((scale_sel == 2'd0) && (h_pos < CNT_W'(H_VIS)) && (v_pos < CNT_W'(V_VIS))
         && (attr_q[5:3] == attr_q[2:0]))
        |=> (pix_color[2:0] == $past(attr_q[2:0])));

endmodule

bind cellvid_raster cellvid_raster_chk #(
    .CNT_W (CNT_W),
    .H_VIS (H_VIS),
    .V_VIS (V_VIS),
    .ACT_W (ACT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_pos      (h_pos),
    .v_pos      (v_pos),
    .scale_sel  (scale_sel),
    .border_col (border_col),
    .attr_q     (attr_q),
    .pix_color  (pix_color)
);

// File: tb/cellvid_raster_bench.sv
module cellvid_raster_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] h_pos;
    logic [10:0] v_pos;
    logic [1:0]  scale_sel;
    logic [2:0]  border_col;
    logic        flash_clk;
    logic [12:0] bmp_addr;
    logic [7:0]  bmp_q;
    logic [9:0]  attr_addr;
    logic [7:0]  attr_q;
    logic [3:0]  pix_color;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0] bmp_mem  [8192];
    logic [7:0] attr_mem [1024];

    always #2.5 clk = ~clk;

    cellvid_raster u_cellvid_raster (
        .clk        (clk),
        .rst_n      (rst_n),
        .h_pos      (h_pos),
        .v_pos      (v_pos),
        .scale_sel  (scale_sel),
        .border_col (border_col),
        .flash_clk  (flash_clk),
        .bmp_addr   (bmp_addr),
        .bmp_q      (bmp_q),
        .attr_addr  (attr_addr),
        .attr_q     (attr_q),
        .pix_color  (pix_color)
    );

    // Video memories read on the falling edge.
    always @(negedge clk) begin
        bmp_q  <= bmp_mem[bmp_addr];
        attr_q <= attr_mem[attr_addr];
    end

    // Stimulus table: {scale_sel, h, v, flash, border}.
    typedef struct packed {
        logic [1:0]  sel;
        logic [10:0] h;
        logic [10:0] v;
        logic        fl;
        logic [2:0]  bc;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 11'd0,    11'd0,   1'b0, 3'd1},  // x4 first pixel
        '{2'd0, 11'd1023, 11'd767, 1'b1, 3'd1},  // x4 last pixel
        '{2'd0, 11'd517,  11'd401, 1'b1, 3'd2},
        '{2'd0, 11'd300,  11'd700, 1'b0, 3'd2},
        '{2'd1, 11'd256,  11'd192, 1'b0, 3'd3},  // x2 first pixel
        '{2'd1, 11'd767,  11'd575, 1'b1, 3'd3},  // x2 last pixel
        '{2'd1, 11'd768,  11'd300, 1'b0, 3'd4},  // x2 right border
        '{2'd1, 11'd255,  11'd300, 1'b0, 3'd5},  // x2 left border
        '{2'd1, 11'd400,  11'd191, 1'b0, 3'd6},  // x2 top border
        '{2'd2, 11'd384,  11'd288, 1'b1, 3'd7},  // x1 first pixel
        '{2'd2, 11'd639,  11'd479, 1'b0, 3'd7},  // x1 last pixel
        '{2'd2, 11'd640,  11'd479, 1'b0, 3'd2},  // x1 right border
        '{2'd3, 11'd500,  11'd350, 1'b1, 3'd1},  // mode 3 equals x1
        '{2'd3, 11'd383,  11'd350, 1'b0, 3'd6},  // mode 3 left border
        '{2'd0, 11'd1024, 11'd10,  1'b0, 3'd7},  // horizontal blank
        '{2'd1, 11'd10,   11'd768, 1'b0, 3'd7}   // vertical blank
    };

    // Reference colour from the requirements (R5 to R9).
    function automatic logic [3:0] ref_colour(logic [1:0] sel, logic [10:0] h,
                                              logic [10:0] v, logic fl, logic [2:0] bc);
        int sh, ox, oy, x, y, ba, aa;
        logic [7:0] b, a;
        logic on;
        if (h >= 1024 || v >= 768) return 4'd0;
        sh = (sel == 0) ? 2 : (sel == 1) ? 1 : 0;
        ox = (sel == 0) ? 0 : (sel == 1) ? 256 : 384;
        oy = (sel == 0) ? 0 : (sel == 1) ? 192 : 288;
        if (h < ox || v < oy || h >= ox + (256 << sh) || v >= oy + (192 << sh))
            return {1'b0, bc};
        x  = (h - ox) >> sh;
        y  = (v - oy) >> sh;
        ba = ((y >> 6) << 11) | ((y & 7) << 8) | (((y >> 3) & 7) << 5) | (x >> 3);
        aa = (y >> 3) * 32 + (x >> 3);
        b  = bmp_mem[ba];
        a  = attr_mem[aa];
        on = b[7 - (x & 7)];
        if (a[7] && fl) on = ~on;
        return {a[6], on ? a[2:0] : a[5:3]};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] sel, logic [10:0] h, logic [10:0] v,
                         logic fl, logic [2:0] bc);
        scale_sel  = sel;
        h_pos      = h;
        v_pos      = v;
        flash_clk  = fl;
        border_col = bc;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8192; i++) bmp_mem[i] = 8'((i * 29) ^ (i >> 5));
        for (int i = 0; i < 1024; i++) attr_mem[i] = 8'((i * 57) + 3);

        // R1: reset clears the output even with a picture position applied.
        rst_n = 1'b0;
        drive(2'd0, 11'd100, 11'd100, 1'b0, 3'd5);
        step(); step(); step();
        check("R1 reset output", 16'(pix_color), 16'h0);
        rst_n = 1'b1;

        // Table walk: R7 scales/origins, R8 borders, R9 blanking, R5/R6 colours.
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].sel, VECS[i].h, VECS[i].v, VECS[i].fl, VECS[i].bc);
            step();
            check($sformatf("R7/R8/R9 vector %0d", i), 16'(pix_color),
                  16'(ref_colour(VECS[i].sel, VECS[i].h, VECS[i].v, VECS[i].fl, VECS[i].bc)));
        end

        // R2, R3: x=93, y=147 in x1 mode gives bitmap 0x134B, attribute 0x24B.
        drive(2'd2, 11'd477, 11'd435, 1'b0, 3'd0);
        #1;
        check("R2 bitmap address", 16'(bmp_addr), 16'h134B);
        check("R3 attribute address", 16'(attr_addr), 16'h24B);

        // R4, R5: byte 0x80 in cell 0, paper 2, ink 5, no bright.
        bmp_mem[0]  = 8'h80;
        attr_mem[0] = 8'b0_0_010_101;
        drive(2'd2, 11'd384, 11'd288, 1'b0, 3'd0);
        step();
        check("R4 MSB is leftmost ink", 16'(pix_color), 16'h5);
        drive(2'd2, 11'd385, 11'd288, 1'b0, 3'd0);
        step();
        check("R4 second pixel paper", 16'(pix_color), 16'h2);

        // R6: flash set with bright; phase high swaps, phase low does not.
        attr_mem[0] = 8'b1_1_010_101;
        drive(2'd2, 11'd384, 11'd288, 1'b1, 3'd0);
        step();
        check("R6 flash swap", 16'(pix_color), 16'hA);
        drive(2'd2, 11'd384, 11'd288, 1'b0, 3'd0);
        step();
        check("R6 flash phase low", 16'(pix_color), 16'hD);

        // R10: output holds until the next rising edge.
        drive(2'd0, 11'd1100, 11'd5, 1'b0, 3'd0);
        step();
        check("R10 blank before move", 16'(pix_color), 16'h0);
        drive(2'd1, 11'd100, 11'd100, 1'b0, 3'd6);
        #1;
        check("R10 no change before edge", 16'(pix_color), 16'h0);
        step();
        check("R10 R8 border after edge", 16'(pix_color), 16'h6);

        // R1: reset mid-run clears the output.
        rst_n = 1'b0;
        step();
        check("R1 reset mid-run", 16'(pix_color), 16'h0);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule